// File: doc/BRIEF.md
# Multiply-Accumulate Unit with Split Accumulator

This block performs the multiply family of a 64-bit integer core. It holds a 64-bit accumulator that is spread over two 64-bit registers: the upper half of the accumulator sits in the low word of `acc_hi`, and the lower half sits in the low word of `acc_lo`. Each register's upper word always carries the sign extension of its low word.

On each cycle where `issue` is high, the block decodes the instruction word. It forms a signed or unsigned 32x32 product from the low words of the two source operands. It then updates the accumulator in one of four ways: set it to the product, set it to the negated product, add the product, or subtract the product. An optional saturating signed add clamps the sum to the 32-bit signed range. In the following cycle the block presents one half of the new accumulator, sign-extended to 64 bits, for writeback to the destination register.

An encoding that matches no variant leaves the accumulator unchanged. It raises `illegal` for one cycle.

Top module: `mac_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `acc_hi`, `acc_lo`, `wb_en` and `illegal` are all zero.
- R2: With opcode bits [31:26] = 0 and function bits [5:0] = 101000, a selector value in bits [10:6] of 00100 (LO returned) or 01100 (HI returned) replaces the accumulator with the signed product. The signed product is the 64-bit product of the low 32 bits of each operand, each taken as signed. The operand bits [63:32] have no effect.
- R3: The same selectors 00101 (LO) and 01101 (HI) use the unsigned product, with both low words zero-extended.
- R4: Under function 101000, selectors 00010 (signed, LO), 00011 (unsigned, LO), 01010 (signed, HI) and 01011 (unsigned, HI) add the product to the accumulator, wrapping modulo 2^64.
- R5: Function 011000 (signed) or 011001 (unsigned) with selector 00011 (LO) or 01011 (HI) sets the accumulator to the two's-complement negation of the product.
- R6: Function 011001 with selector 00111 (LO), and function 011000 or 011001 with selector 01111 (HI), subtract the product from the accumulator.
- R7: After every update, `acc_hi` equals the accumulator's upper 32 bits sign-extended to 64 bits, and `acc_lo` equals its lower 32 bits sign-extended.
- R8: One cycle after an issued legal variant that writes back, `wb_en` is high for one cycle. `wb_data` then equals the selected half of the new accumulator, sign-extended, which is the new `acc_hi` or `acc_lo`.
- R9: Function 101000 with selector 00000 performs a signed accumulate and leaves `wb_en` low.
- R10: Function 101000 with selector 10000 (LO) or 11000 (HI) is a saturating signed accumulate. The accumulator plus the signed product is computed without overflow. A result above 0x7FFFFFFF becomes 0x000000007FFFFFFF.
- R11: In the same saturating mode, a result below -2^31 becomes 0xFFFFFFFF80000000.
- R12: An issued encoding that matches none of the above, including a nonzero opcode, leaves `acc_hi` and `acc_lo` unchanged. It keeps `wb_en` low and raises `illegal` for exactly the following cycle.
- R13: While `issue` is low, the accumulator is unchanged and `wb_en` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue | input | 1 | Instruction strobe for this cycle |
| insn | input | 32 | Decoded instruction word |
| src_a | input | 64 | First source operand |
| src_b | input | 64 | Second source operand |
| acc_hi | output | 64 | Upper accumulator register |
| acc_lo | output | 64 | Lower accumulator register |
| wb_en | output | 1 | Destination write strobe |
| wb_data | output | 64 | Destination write value |
| illegal | output | 1 | Unmatched-encoding pulse |

## Verification
The hardest states to reach are the saturation boundaries. They depend on the accumulator value left behind by earlier instructions, so no single issue can reach them from the ports. The stimulus table therefore chains instructions. A plain multiply first loads a value just below the positive limit or exactly at the negative limit, and the saturating accumulate follows.

Another chained pair loads a large negative 64-bit accumulator and then saturates from it. This exercises the case where the sum lies far outside the 32-bit range rather than just past its edge.

Illegal encodings are placed between legal updates, so the bench can see that the accumulator they follow is carried through unchanged.

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue,
  input  logic [31:0]     insn,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  output logic [XLEN-1:0] acc_hi,
  output logic [XLEN-1:0] acc_lo,
  output logic            wb_en,
  output logic [XLEN-1:0] wb_data,
  output logic            illegal
);
  localparam int HALF = XLEN / 2;
  localparam int WIDE = XLEN + 2;
  localparam logic [WIDE-1:0] SAT_MAX = {{(WIDE-HALF+1){1'b0}}, {(HALF-1){1'b1}}};
  localparam logic [WIDE-1:0] SAT_MIN = {{(WIDE-HALF+1){1'b1}}, {(HALF-1){1'b0}}};

  typedef enum logic [1:0] {OP_SET, OP_NEG, OP_ADD, OP_SUB} acc_op_e;

  logic [5:0] opc, fn;
  logic [4:0] sel;
  assign opc = insn[31:26];
  assign sel = insn[10:6];
  assign fn  = insn[5:0];

  logic    legal, uns, take_hi, wr, sat;
  acc_op_e op;

  always_comb begin
    legal   = 1'b0;
    uns     = 1'b0;
    take_hi = 1'b0;
    wr      = 1'b1;
    sat     = 1'b0;
    op      = OP_ADD;
    if (opc == 6'b000000) begin
      case (fn)
        6'b101000: begin
          case (sel)
            5'b00000: begin legal = 1'b1; wr = 1'b0; end
            5'b00010: legal = 1'b1;
            5'b00011: begin legal = 1'b1; uns = 1'b1; end
            5'b01010: begin legal = 1'b1; take_hi = 1'b1; end
            5'b01011: begin legal = 1'b1; uns = 1'b1; take_hi = 1'b1; end
            5'b00100: begin legal = 1'b1; op = OP_SET; end
            5'b00101: begin legal = 1'b1; op = OP_SET; uns = 1'b1; end
            5'b01100: begin legal = 1'b1; op = OP_SET; take_hi = 1'b1; end
            5'b01101: begin legal = 1'b1; op = OP_SET; uns = 1'b1; take_hi = 1'b1; end
            5'b10000: begin legal = 1'b1; sat = 1'b1; end
            5'b11000: begin legal = 1'b1; sat = 1'b1; take_hi = 1'b1; end
            default:  legal = 1'b0;
          endcase
        end
        6'b011000, 6'b011001: begin
          uns = fn[0];
          case (sel)
            5'b00011: begin legal = 1'b1; op = OP_NEG; end
            5'b01011: begin legal = 1'b1; op = OP_NEG; take_hi = 1'b1; end
            5'b00111: begin legal = fn[0]; op = OP_SUB; end
            5'b01111: begin legal = 1'b1; op = OP_SUB; take_hi = 1'b1; end
            default:  legal = 1'b0;
          endcase
        end
        default: legal = 1'b0;
      endcase
    end
  end

  logic [XLEN-1:0] ext_a, ext_b, prod, acc, acc_nx, hi_nx, lo_nx;
  logic [WIDE-1:0] sum_w;

  assign ext_a = {{HALF{~uns & src_a[HALF-1]}}, src_a[HALF-1:0]};
  assign ext_b = {{HALF{~uns & src_b[HALF-1]}}, src_b[HALF-1:0]};
  assign prod  = ext_a * ext_b;
  assign acc   = {acc_hi[HALF-1:0], acc_lo[HALF-1:0]};
  assign sum_w = {{2{acc[XLEN-1]}}, acc} + {{2{prod[XLEN-1]}}, prod};

  always_comb begin
    if (sat) begin
      if ($signed(sum_w) > $signed(SAT_MAX))      acc_nx = SAT_MAX[XLEN-1:0];
      else if ($signed(sum_w) < $signed(SAT_MIN)) acc_nx = SAT_MIN[XLEN-1:0];
      else                                        acc_nx = sum_w[XLEN-1:0];
    end else begin
      case (op)
        OP_SET:  acc_nx = prod;
        OP_NEG:  acc_nx = -prod;
        OP_SUB:  acc_nx = acc - prod;
        default: acc_nx = acc + prod;
      endcase
    end
  end

  assign hi_nx = {{HALF{acc_nx[XLEN-1]}}, acc_nx[XLEN-1:HALF]};
  assign lo_nx = {{HALF{acc_nx[HALF-1]}}, acc_nx[HALF-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_hi  <= '0;
      acc_lo  <= '0;
      wb_en   <= 1'b0;
      wb_data <= '0;
      illegal <= 1'b0;
    end else begin
      wb_en   <= issue & legal & wr;
      illegal <= issue & ~legal;
      if (issue && legal) begin
        acc_hi <= hi_nx;
        acc_lo <= lo_nx;
        if (wr) wb_data <= take_hi ? hi_nx : lo_nx;
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{insn[25:11], src_a[XLEN-1:HALF], src_b[XLEN-1:HALF],
                         acc_hi[XLEN-1:HALF], acc_lo[XLEN-1:HALF]};
endmodule

// File: rtl/mac_unit_chk.sv
module mac_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue,
  input logic [31:0]     insn,
  input logic [XLEN-1:0] acc_hi,
  input logic [XLEN-1:0] acc_lo,
  input logic            wb_en,
  input logic [XLEN-1:0] wb_data,
  input logic            illegal
);
  // R13
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> ($stable(acc_hi) && $stable(acc_lo) && !wb_en && !illegal));

  // R12
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (acc_hi == $past(acc_hi) && acc_lo == $past(acc_lo) && !wb_en));

  // R12
  illegal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(issue));

  // R8
  wb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> $past(issue));

  // R8
  wb_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (wb_data == acc_hi || wb_data == acc_lo));

  // R10 R11
  sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && $past(insn[31:26] == 6'b0 && insn[5:0] == 6'b101000 && insn[10]))
      |-> (acc_hi == '0 || acc_hi == '1));
endmodule

bind mac_unit mac_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
  .acc_hi(acc_hi), .acc_lo(acc_lo), .wb_en(wb_en), .wb_data(wb_data),
  .illegal(illegal)
);

// File: tb/mac_unit_bench.sv
`timescale 1ns/1ps
module mac_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [63:0] acc_hi, acc_lo, wb_data;
  logic        wb_en, illegal;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mac_unit u_mac_unit (
    .clk(clk), .rst_n(rst_n), .issue(issue), .insn(insn),
    .src_a(src_a), .src_b(src_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .wb_en(wb_en), .wb_data(wb_data), .illegal(illegal)
  );

  localparam logic [5:0]  FA   = 6'b101000;
  localparam logic [5:0]  FS   = 6'b011000;
  localparam logic [5:0]  FU   = 6'b011001;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic [4:0]  sel;
    logic [5:0]  fn;
    logic [63:0] a;
    logic [63:0] b;
    logic        wen;
    logic        ill;
    logic [63:0] wb;
    logic [63:0] hi;
    logic [63:0] lo;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{5'b00100, FA, 64'h12345678_FFFFFFFD, 64'h7, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFEB, ONES, 64'hFFFFFFFF_FFFFFFEB, 8'd2},   // R2
    '{5'b00101, FA, 64'hFFFFFFFD, 64'h7, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFEB, 64'h6, 64'hFFFFFFFF_FFFFFFEB, 8'd3},              // R3
    '{5'b01100, FA, 64'h10000, 64'h30000, 1'b1, 1'b0, 64'h3, 64'h3, 64'h0, 8'd2},                                             // R2
    '{5'b01101, FA, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFE, 64'h1, 8'd7},        // R7
    '{5'b00010, FA, 64'h2, 64'h3, 1'b1, 1'b0, 64'h7, 64'hFFFFFFFF_FFFFFFFE, 64'h7, 8'd4},                                     // R4
    '{5'b01010, FA, 64'hFFFFFFFF, 64'h1, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFE, 64'h6, 8'd4},               // R4
    '{5'b00011, FA, 64'hFFFFFFFF, 64'h1, 1'b1, 1'b0, 64'h5, ONES, 64'h5, 8'd4},                                               // R4
    '{5'b01011, FA, 64'hFFFFFFFF, 64'h2, 1'b1, 1'b0, 64'h1, 64'h1, 64'h3, 8'd4},                                              // R4
    '{5'b00011, FS, 64'h5, 64'h6, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFE2, ONES, 64'hFFFFFFFF_FFFFFFE2, 8'd5},                      // R5
    '{5'b01011, FU, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b0, 64'h1, 64'h1, ONES, 8'd5},                                        // R5
    '{5'b01011, FS, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b0, ONES, ONES, ONES, 8'd5},                                          // R5
    '{5'b00011, FU, 64'h1, 64'h4, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFC, ONES, 64'hFFFFFFFF_FFFFFFFC, 8'd5},                      // R5
    '{5'b00111, FU, 64'h10, 64'h1, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFEC, ONES, 64'hFFFFFFFF_FFFFFFEC, 8'd6},                     // R6
    '{5'b01111, FS, 64'hFFFFFFFF, 64'h10000, 1'b1, 1'b0, 64'h0, 64'h0, 64'hFFEC, 8'd6},                                       // R6
    '{5'b01111, FU, 64'h80000000, 64'h2, 1'b1, 1'b0, ONES, ONES, 64'hFFEC, 8'd6},                                             // R6
    '{5'b00111, FS, 64'h3, 64'h3, 1'b0, 1'b1, 64'h0, ONES, 64'hFFEC, 8'd12},                                                  // R12
    '{5'b00000, FA, 64'h2, 64'hFFFFFFFF, 1'b0, 1'b0, 64'h0, ONES, 64'hFFEA, 8'd9},                                            // R9
    '{5'b00001, FA, 64'h1, 64'h1, 1'b0, 1'b1, 64'h0, ONES, 64'hFFEA, 8'd12},                                                  // R12
    '{5'b00100, FA, 64'h7FFFFFF0, 64'h1, 1'b1, 1'b0, 64'h7FFFFFF0, 64'h0, 64'h7FFFFFF0, 8'd2},                                // R2
    '{5'b10000, FA, 64'h100, 64'h1, 1'b1, 1'b0, 64'h7FFFFFFF, 64'h0, 64'h7FFFFFFF, 8'd10},                                    // R10
    '{5'b11000, FA, 64'hFFFFFFFF, 64'h10, 1'b1, 1'b0, 64'h0, 64'h0, 64'h7FFFFFEF, 8'd10},                                     // R10
    '{5'b00100, FA, 64'h80000000, 64'h1, 1'b1, 1'b0, 64'hFFFFFFFF_80000000, ONES, 64'hFFFFFFFF_80000000, 8'd2},               // R2
    '{5'b10000, FA, 64'hFFFFFFFF, 64'h5, 1'b1, 1'b0, 64'hFFFFFFFF_80000000, ONES, 64'hFFFFFFFF_80000000, 8'd11},              // R11
    '{5'b00010, FA, 64'hFFFFFFFF, 64'h5, 1'b1, 1'b0, 64'h7FFFFFFB, ONES, 64'h7FFFFFFB, 8'd4},                                 // R4
    '{5'b01101, FA, 64'hFFFFFFFF, 64'hFFFFFFFF, 1'b1, 1'b0, 64'hFFFFFFFF_FFFFFFFE, 64'hFFFFFFFF_FFFFFFFE, 64'h1, 8'd3},        // R3
    '{5'b10000, FA, 64'h1, 64'h1, 1'b1, 1'b0, 64'hFFFFFFFF_80000000, ONES, 64'hFFFFFFFF_80000000, 8'd11},                     // R11
    '{5'b10001, FA, 64'h1, 64'h1, 1'b0, 1'b1, 64'h0, ONES, 64'hFFFFFFFF_80000000, 8'd12}                                      // R12
  };

  task automatic chk(input int req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [5:0] opc, input logic [4:0] sel, input logic [5:0] fn);
    return {opc, 5'd4, 5'd5, 5'd6, sel, fn};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 50000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [63:0] hold_hi, hold_lo;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(1, "hi in reset", acc_hi, '0);
    chk(1, "lo in reset", acc_lo, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(1, "hi after reset", acc_hi, '0);
    chk(1, "lo after reset", acc_lo, '0);
    chk(1, "wb_en after reset", {63'b0, wb_en}, 64'h0);
    chk(1, "illegal after reset", {63'b0, illegal}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      issue = 1'b1;
      insn  = mk(6'b000000, VECS[i].sel, VECS[i].fn);
      src_a = VECS[i].a;
      src_b = VECS[i].b;
      @(negedge clk);
      chk(VECS[i].req, $sformatf("row %0d wb_en (R8)", i), {63'b0, wb_en}, {63'b0, VECS[i].wen});
      chk(VECS[i].req, $sformatf("row %0d illegal", i), {63'b0, illegal}, {63'b0, VECS[i].ill});
      if (VECS[i].wen) chk(VECS[i].req, $sformatf("row %0d wb_data (R8)", i), wb_data, VECS[i].wb);
      chk(VECS[i].req, $sformatf("row %0d hi (R7)", i), acc_hi, VECS[i].hi);
      chk(VECS[i].req, $sformatf("row %0d lo (R7)", i), acc_lo, VECS[i].lo);
    end

    // R12 illegal lasts one cycle, R8 wb_en lasts one cycle
    issue = 1'b0;
    @(negedge clk);
    chk(12, "illegal drops", {63'b0, illegal}, 64'h0);
    chk(8, "wb_en idle", {63'b0, wb_en}, 64'h0);

    // R13 no issue, valid-looking word present
    hold_hi = acc_hi;
    hold_lo = acc_lo;
    insn  = mk(6'b000000, 5'b00100, FA);
    src_a = 64'h5;
    src_b = 64'h5;
    repeat (4) @(negedge clk);
    chk(13, "hi idle", acc_hi, hold_hi);
    chk(13, "lo idle", acc_lo, hold_lo);
    chk(13, "wb_en idle", {63'b0, wb_en}, 64'h0);

    // R12 nonzero opcode
    issue = 1'b1;
    insn  = mk(6'b011100, 5'b00100, FA);
    @(negedge clk);
    issue = 1'b0;
    chk(12, "opcode illegal flag", {63'b0, illegal}, 64'h1);
    chk(12, "opcode illegal wb_en", {63'b0, wb_en}, 64'h0);
    chk(12, "opcode illegal hi", acc_hi, hold_hi);
    chk(12, "opcode illegal lo", acc_lo, hold_lo);
    @(negedge clk);
    chk(12, "opcode illegal one cycle", {63'b0, illegal}, 64'h0);

    // R2 back-to-back after idle, then R1 mid-run reset
    issue = 1'b1;
    insn  = mk(6'b000000, 5'b00100, FA);
    src_a = 64'h5;
    src_b = 64'hFFFFFFFF_FFFFFFFE;
    @(negedge clk);
    issue = 1'b0;
    chk(2, "mul -10 lo", acc_lo, 64'hFFFFFFFF_FFFFFFF6);
    chk(2, "mul -10 wb", wb_data, 64'hFFFFFFFF_FFFFFFF6);
    rst_n = 1'b0;
    @(negedge clk);
    chk(1, "hi reset mid-run", acc_hi, '0);
    chk(1, "lo reset mid-run", acc_lo, '0);
    chk(1, "wb_en reset mid-run", {63'b0, wb_en}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule